// File: doc/BRIEF.md
# Bit-band alias bridge

This bridge sits between a single-beat memory master and a word-wide single-port synchronous SRAM. It gives every bit of a primary SRAM region its own 32-bit word address in a separate alias window. A store to an alias word sets or clears exactly one bit of the backing memory, so the master never performs a read-modify-write itself. A load from an alias word returns that one bit. Ordinary loads and stores to the primary region pass straight to the SRAM.

The controller has two states. In IDLE the bridge accepts requests (ready high), forwards primary-region accesses in the same cycle, and starts the backing-word read for any alias access. An accepted alias write causes the IDLE-to-MODIFY transition. In MODIFY, ready is low while the bridge writes the backing word back with only the addressed bit replaced. MODIFY always returns to IDLE after one cycle. Every other accepted request leaves the controller in IDLE. Each accepted request produces exactly one response pulse. That pulse comes one cycle after the request's last SRAM cycle, or one cycle after acceptance when the request touches no SRAM.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is asserted and right after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_en` is 0.
- R2: A request in the primary region (`REGION_BASE` up to `REGION_BYTES` bytes) goes to SRAM word `(addr-REGION_BASE)>>2` in the accept cycle, using the master's byte enables (`req_be[i]` covers bits 8i+7:8i). Its response comes one cycle later, and read data is the full SRAM word.
- R3: The alias address `ALIAS_BASE + (byte_offset<<5) + (bit<<2)` selects bit `8*(byte_offset%4)+bit` of SRAM word `byte_offset/4`, which is little-endian within the word.
- R4: An alias write takes only `req_wdata[0]` as the new bit value. `req_wdata[31:1]` and `req_be` have no effect.
- R5: An alias write leaves every other bit of the backing word and every other SRAM word unchanged.
- R6: An alias write uses two SRAM cycles: a read in the accept cycle, then a full-word write to the same word. `req_ready` is 0 during the write cycle, and `rsp_valid` rises one cycle after the write.
- R7: An alias read returns the addressed bit in `rsp_rdata[0]` with zeros in bits 31:1, one cycle after acceptance.
- R8: Address bits 1:0 of an alias access are ignored.
- R9: A request that hits neither window causes no SRAM access. It is acknowledged one cycle later with `rsp_rdata` equal to 0.
- R10: The alias window spans exactly `32*REGION_BYTES` bytes. Its last word reaches bit 31 of the last SRAM word, and the first address past it is treated as outside both windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Byte enables for primary-region stores |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Load data, zero for stores |
| mem_en | output | 1 | SRAM cycle enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | WORD_AW | SRAM word address |
| mem_be | output | 4 | SRAM byte write enables |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, valid one cycle after a read |

## Verification
Primary stores with full and sparse byte enables set up a word with mixed ones and zeros. This separates a correct byte-lane merge from a full overwrite. Alias loads and stores then target bits in all four bytes of that word, which exposes a wrong byte-to-lane order or a wrong bit shift. Stores whose upper data bits are set while bit 0 is clear, or with all byte enables off, show whether only data bit 0 is used. Word read-backs after each alias store reveal any disturbance of the other 31 bits. The last alias word, the first address past the alias window, the first byte past the primary window and an address below it tell an exact-span decode apart from one that wraps or over-reaches.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_MODIFY
    } bb_state_e;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_WORD,
        RK_BIT,
        RK_ACK
    } rsp_kind_e;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_PRIMARY,
        RG_ALIAS
    } region_e;

endpackage

// File: rtl/bb_decode.sv
module bb_decode
    import bb_pkg::*;
#(
    parameter logic [31:0] REGION_BASE  = 32'h2000_0000,
    parameter logic [31:0] ALIAS_BASE   = 32'h2200_0000,
    parameter int unsigned REGION_BYTES = 4096,
    localparam int BYTE_AW = $clog2(REGION_BYTES),
    localparam int WORD_AW = BYTE_AW - 2
) (
    input  logic [31:0]        addr,
    output region_e            region,
    output logic [WORD_AW-1:0] word_addr,
    output logic [4:0]         bit_sel
);

    localparam logic [31:0] PRIM_SPAN  = 32'(REGION_BYTES);
    localparam logic [31:0] ALIAS_SPAN = 32'(REGION_BYTES) << 5;

    logic [31:0] prim_off;
    logic [31:0] alias_off;
    logic        prim_hit;
    logic        alias_hit;

    always_comb begin
        prim_off  = addr - REGION_BASE;
        alias_off = addr - ALIAS_BASE;
        prim_hit  = (addr >= REGION_BASE) && (prim_off < PRIM_SPAN);
        alias_hit = (addr >= ALIAS_BASE) && (alias_off < ALIAS_SPAN);

        if (prim_hit)       region = RG_PRIMARY;
        else if (alias_hit) region = RG_ALIAS;
        else                region = RG_NONE;

        // R3: alias offset bits above 6 carry the backing word, bits 6:2 the bit within it
        word_addr = prim_hit ? prim_off[BYTE_AW-1:2] : alias_off[BYTE_AW+4:7];
        bit_sel   = alias_off[6:2];
    end

    // R10
    span_excl_chk: assert final (!(prim_hit && alias_hit));

endmodule

// File: rtl/bb_bitops.sv
module bb_bitops #(
    parameter int WORD_W = 32,
    localparam int SEL_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              new_bit,
    output logic              bit_out,
    output logic [WORD_W-1:0] word_out
);

    always_comb begin
        bit_out = word_in[bit_sel];
        for (int i = 0; i < WORD_W; i++) begin
            word_out[i] = (i == int'(bit_sel)) ? new_bit : word_in[i];
        end
    end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter logic [31:0] REGION_BASE  = 32'h2000_0000,
    parameter logic [31:0] ALIAS_BASE   = 32'h2200_0000,
    parameter int unsigned REGION_BYTES = 4096,
    localparam int BYTE_AW = $clog2(REGION_BYTES),
    localparam int WORD_AW = BYTE_AW - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [31:0]        req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [3:0]         req_be,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WORD_AW-1:0] mem_addr,
    output logic [3:0]         mem_be,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata
);

    bb_state_e          state_q, state_d;
    rsp_kind_e          kind_q, kind_d;
    logic [WORD_AW-1:0] hold_addr_q;
    logic [4:0]         hold_bit_q;
    logic               hold_val_q;

    region_e            dec_region;
    logic [WORD_AW-1:0] dec_word;
    logic [4:0]         dec_bit;
    logic               sel_bit;
    logic [31:0]        merged_word;
    logic               accept;

    bb_decode #(
        .REGION_BASE (REGION_BASE),
        .ALIAS_BASE  (ALIAS_BASE),
        .REGION_BYTES(REGION_BYTES)
    ) u_decode (
        .addr     (req_addr),
        .region   (dec_region),
        .word_addr(dec_word),
        .bit_sel  (dec_bit)
    );

    bb_bitops #(.WORD_W(32)) u_bitops (
        .word_in (mem_rdata),
        .bit_sel (hold_bit_q),
        .new_bit (hold_val_q),
        .bit_out (sel_bit),
        .word_out(merged_word)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // Next state and response kind
    always_comb begin
        state_d = state_q;
        kind_d  = RK_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (dec_region)
                        RG_PRIMARY: kind_d = req_write ? RK_ACK : RK_WORD;
                        RG_ALIAS: begin
                            if (req_write) state_d = ST_MODIFY;
                            else           kind_d  = RK_BIT;
                        end
                        default:    kind_d = RK_ACK;
                    endcase
                end
            end
            ST_MODIFY: begin
                state_d = ST_IDLE;
                kind_d  = RK_ACK;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            kind_q      <= RK_NONE;
            hold_addr_q <= '0;
            hold_bit_q  <= '0;
            hold_val_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            if (accept) begin
                hold_addr_q <= dec_word;
                hold_bit_q  <= dec_bit;
                hold_val_q  <= req_wdata[0];
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dec_word;
        mem_be    = 4'hF;
        mem_wdata = req_wdata;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                mem_en    = req_valid && (dec_region != RG_NONE);
                mem_we    = req_write && (dec_region == RG_PRIMARY);
                if (dec_region == RG_PRIMARY) mem_be = req_be;
            end
            ST_MODIFY: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = hold_addr_q;
                mem_wdata = merged_word;
            end
        endcase
    end

    always_comb begin
        rsp_valid = (kind_q != RK_NONE);
        unique case (kind_q)
            RK_WORD: rsp_rdata = mem_rdata;
            RK_BIT:  rsp_rdata = {31'b0, sel_bit};
            default: rsp_rdata = '0;
        endcase
    end

    // R6
    rmw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_region == RG_ALIAS && req_write) |=> (!req_ready && mem_en && mem_we));

    // R6
    rmw_same_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODIFY) |-> (mem_addr == $past(mem_addr)));

    // R5
    rmw_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODIFY) |-> ($countones(mem_wdata ^ mem_rdata) <= 1));

    // R2
    single_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(dec_region == RG_ALIAS && req_write)) |=> rsp_valid);

    // R9
    miss_no_sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_region == RG_NONE) |-> !mem_en);

    // R7
    bit_rsp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(accept && dec_region == RG_ALIAS && !req_write)) |-> (rsp_rdata[31:1] == '0));

endmodule

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb;

    localparam int          RB      = 256;
    localparam int          WAW     = $clog2(RB) - 2;
    localparam logic [31:0] P_BASE  = 32'h2000_0000;
    localparam logic [31:0] A_BASE  = 32'h2200_0000;
    localparam int          NV      = 24;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [31:0] exp;
        logic [7:0]  rq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h2000_0010, 32'h1234_5678, 4'hF, 32'h0,          8'd2},  // R2
        '{1'b0, 32'h2000_0010, 32'h0,         4'hF, 32'h1234_5678, 8'd2},  // R2
        '{1'b1, 32'h2000_0010, 32'hAABB_CCDD, 4'h5, 32'h0,          8'd2},  // R2 sparse lanes
        '{1'b0, 32'h2000_0010, 32'h0,         4'hF, 32'h12BB_56DD, 8'd2},  // R2
        '{1'b0, 32'h2200_0200, 32'h0,         4'hF, 32'h1,          8'd7},  // R7
        '{1'b0, 32'h2200_0204, 32'h0,         4'hF, 32'h0,          8'd3},  // R3
        '{1'b0, 32'h2200_0270, 32'h0,         4'hF, 32'h1,          8'd3},  // R3 byte 3
        '{1'b1, 32'h2200_0260, 32'h0000_0001, 4'h0, 32'h0,          8'd4},  // R4 be ignored
        '{1'b0, 32'h2000_0010, 32'h0,         4'hF, 32'h13BB_56DD, 8'd5},  // R5
        '{1'b1, 32'h2200_025C, 32'hFFFF_FFFE, 4'hF, 32'h0,          8'd4},  // R4 only bit 0
        '{1'b0, 32'h2000_0010, 32'h0,         4'hF, 32'h133B_56DD, 8'd5},  // R5
        '{1'b0, 32'h2200_025F, 32'h0,         4'hF, 32'h0,          8'd8},  // R8
        '{1'b0, 32'h2200_0273, 32'h0,         4'hF, 32'h1,          8'd8},  // R8
        '{1'b1, 32'h2200_0206, 32'h0000_0001, 4'hF, 32'h0,          8'd8},  // R8
        '{1'b0, 32'h2000_0010, 32'h0,         4'hF, 32'h133B_56DF, 8'd8},  // R8
        '{1'b1, 32'h2200_1FFC, 32'h0000_0001, 4'hF, 32'h0,          8'd10}, // R10 last alias word
        '{1'b0, 32'h2000_00FC, 32'h0,         4'hF, 32'h8000_0000, 8'd10}, // R10
        '{1'b0, 32'h2200_1FFC, 32'h0,         4'hF, 32'h1,          8'd10}, // R10
        '{1'b1, 32'h2200_2000, 32'hFFFF_FFFF, 4'hF, 32'h0,          8'd10}, // R10 past window
        '{1'b0, 32'h2000_0000, 32'h0,         4'hF, 32'h0,          8'd10}, // R10 no wrap
        '{1'b1, 32'h2000_0100, 32'hFFFF_FFFF, 4'hF, 32'h0,          8'd9},  // R9
        '{1'b0, 32'h2000_0100, 32'h0,         4'hF, 32'h0,          8'd9},  // R9
        '{1'b0, 32'h2000_0000, 32'h0,         4'hF, 32'h0,          8'd9},  // R9
        '{1'b0, 32'h1FFF_FFFC, 32'h0,         4'hF, 32'h0,          8'd9}   // R9
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic           req_write = 1'b0;
    logic [31:0]    req_addr = '0;
    logic [31:0]    req_wdata = '0;
    logic [3:0]     req_be = '0;
    logic           rsp_valid;
    logic [31:0]    rsp_rdata;
    logic           mem_en;
    logic           mem_we;
    logic [WAW-1:0] mem_addr;
    logic [3:0]     mem_be;
    logic [31:0]    mem_wdata;
    logic [31:0]    mem_rdata = '0;

    logic [31:0]    sram [2**WAW];
    int             en_cnt = 0;
    int             checks = 0;
    int             fails = 0;

    always #2.5 clk = ~clk;

    bitband_bridge #(
        .REGION_BASE (P_BASE),
        .ALIAS_BASE  (A_BASE),
        .REGION_BYTES(RB)
    ) u_dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr,
        .req_wdata, .req_be, .rsp_valid, .rsp_rdata, .mem_en, .mem_we,
        .mem_addr, .mem_be, .mem_wdata, .mem_rdata
    );

    initial for (int i = 0; i < 2**WAW; i++) sram[i] = '0;

    always @(posedge clk) begin
        if (mem_en) begin
            en_cnt <= en_cnt + 1;
            mem_rdata <= sram[mem_addr];
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) sram[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        bit    in_p, in_a, a_wr;
        int    lat, en0, en_exp;
        string tag;
        tag  = $sformatf("R%0d", v.rq);
        in_p = (v.addr >= P_BASE) && (v.addr - P_BASE < RB);
        in_a = (v.addr >= A_BASE) && (v.addr - A_BASE < RB * 32);
        a_wr = in_a && v.wr;
        en_exp = a_wr ? 2 : ((in_p || in_a) ? 1 : 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
        req_wdata = v.wdata; req_be = v.be;
        en0 = en_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (a_wr) check(req_ready == 1'b0, "R6 ready low in write-back", 32'(req_ready), 32'h0);
        while (!rsp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        check(lat == (a_wr ? 2 : 1), {tag, " response latency"}, 32'(lat), 32'(a_wr ? 2 : 1));
        check(en_cnt - en0 == en_exp, {tag, " SRAM cycle count"}, 32'(en_cnt - en0), 32'(en_exp));
        if (!v.wr) check(rsp_rdata == v.exp, {tag, " read data"}, rsp_rdata, v.exp);
        else       check(rsp_rdata == 32'h0, {tag, " store response data"}, rsp_rdata, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'h1);
        check(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
        check(mem_en == 1'b0, "R1 mem_en in reset", 32'(mem_en), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_en == 1'b0, "R1 after reset",
              {29'b0, req_ready, rsp_valid, mem_en}, 32'h4);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6: idle cycles between requests produce no response and no SRAM cycle
        @(negedge clk);
        check(rsp_valid == 1'b0 && mem_en == 1'b0, "R6 quiet after response",
              {30'b0, rsp_valid, mem_en}, 32'h0);

        // R5: words neighbouring the modified one remain zero
        check(sram[3] == 32'h0, "R5 neighbour word below", sram[3], 32'h0);
        check(sram[5] == 32'h0, "R5 neighbour word above", sram[5], 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule